// File: doc/BRIEF.md
# Byte-Lane Memory Slave with Wait-State Acknowledge

This block is the user-logic end of a synchronous bus-to-peripheral handshake. An upstream bus adapter presents a chip-select vector, an address, a read/not-write flag, write data and per-byte enables. The block answers every request with a one-cycle read or write acknowledge pulse. It holds a small word-addressed RAM that is mapped into one naturally aligned, power-of-two memory region.

Each request starts when the selected chip-select bit rises. A counter then adds `WAIT_CYCLES` wait states before the acknowledge is returned. Writes update only the byte lanes whose enables are set. Lanes are numbered big-endian: lane 0 is the most significant byte. Two kinds of access are answered with the error flag set in the acknowledge cycle: an access whose address lies outside the region, and an access whose word index lies beyond the implemented depth. Such a read returns zero and such a write changes nothing. Read data is zero in every cycle without a read acknowledge.

Top module: `lane_mem_slave`

## Requirements
- R1: Synchronous reset (`rst_n` low at a clock edge) clears `rd_ack`, `wr_ack`, `err` and `rd_data` to zero.
- R2: If the selected chip-select bit is first sampled high at clock edge E, exactly one acknowledge pulse is given. It is high for the single cycle after edge E+WAIT_CYCLES+1. No further acknowledge follows while chip select stays high.
- R3: A request with `rnw`=1 is answered only on `rd_ack`, and a request with `rnw`=0 only on `wr_ack`. The two are never high together.
- R4: Enable bit `be[j]` (lane NB-1-j in big-endian numbering) guards data bits [8j+7:8j]. A write with `be`=4'b0011 on a 32-bit bus replaces only the two least-significant bytes.
- R5: Byte lanes whose enable is low keep their previous contents across a write.
- R6: An in-region access with word index (address bits above the byte offset) at or above DEPTH is acknowledged with `err`=1, and such a read returns zero data.
- R7: An out-of-depth write leaves every implemented word unchanged, including the word its index would alias to.
- R8: An access whose address bits above the region size differ from BASE_ADDR is acknowledged with `err`=1 and does not write the RAM.
- R9: `err` is high only in a cycle where `rd_ack` or `wr_ack` is high.
- R10: `rd_data` is zero in every cycle where `rd_ack` is low.
- R11: Only chip-select bit CS_SEL starts a request. Activity on the other bits produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every interface signal |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Byte address of the request |
| cs | input | CS_W | Chip-select vector; bit CS_SEL selects this memory |
| rnw | input | 1 | 1 = read, 0 = write; meaningful while selected |
| wdata | input | DATA_W | Write data |
| be | input | DATA_W/8 | Byte enables, big-endian lane numbering |
| rd_data | output | DATA_W | Read data, zero outside a read acknowledge |
| rd_ack | output | 1 | One-cycle read acknowledge |
| wr_ack | output | 1 | One-cycle write acknowledge |
| err | output | 1 | Error flag, only alongside an acknowledge |

## Verification
With the default WAIT_CYCLES of 2, the chip select is raised after a falling edge. The acknowledge, `err` and `rd_data` are then due at the falling edge that follows the fourth rising edge, which is WAIT_CYCLES+2 edges later. Each access task samples at every falling edge while chip select is held. It records the index of the first acknowledge and the number of acknowledges, and compares that index with WAIT_CYCLES+2 exactly. In every sampled cycle without an acknowledge it also checks that `rd_data` and `err` are zero. Stored contents are always checked through a later read, never by peeking into the RAM.

// File: rtl/lane_mem_pkg.sv
// Package: shared types for the byte-lane memory slave.
// Assumes: byte-granular lanes of 8 bits.
package lane_mem_pkg;

    // Sequencing states of the acknowledge timer.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_COUNT = 2'd1,
        SEQ_HOLD  = 2'd2
    } seq_state_e;

    localparam int LANE_BITS = 8;

endpackage

// File: rtl/lane_mem_decode.sv
// Module: lane_mem_decode
// Splits a byte address into region hit, depth range check and word index.
// Assumes: the region is 2**REGION_LG bytes, aligned on BASE_ADDR, and
// DEPTH is a power of two whose words fit in the region.
module lane_mem_decode #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          DEPTH     = 256,
    parameter int          REGION_LG = 12,
    parameter logic [31:0] BASE_ADDR = 32'h0000_4000
) (
    input  logic [ADDR_W-1:0]         addr,
    output logic                      region_hit,
    output logic                      depth_ok,
    output logic [$clog2(DEPTH)-1:0]  word_idx
);
    localparam int NB       = DATA_W / 8;
    localparam int BYTE_LG  = $clog2(NB);
    localparam int DEPTH_LG = $clog2(DEPTH);
    localparam int IDX_W    = REGION_LG - BYTE_LG;
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

    logic unused_low;

    // Region compare: only the bits above the region size matter.
    always_comb begin
        region_hit = (addr[ADDR_W-1:REGION_LG] == BASE_V[ADDR_W-1:REGION_LG]);
        word_idx   = addr[BYTE_LG +: DEPTH_LG];
        unused_low = &{1'b1, addr[BYTE_LG-1:0]};
    end

    // Depth check: any index bit above the implemented depth is out of range.
    generate
        if (IDX_W > DEPTH_LG) begin : g_partial
            always_comb depth_ok = (addr[REGION_LG-1:BYTE_LG+DEPTH_LG] == '0);
        end else begin : g_full
            always_comb depth_ok = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/lane_mem_timer.sv
// Module: lane_mem_timer
// Detects a new request on the selected chip select, counts WAIT_CYCLES
// wait states, then raises fire for one cycle and waits for the request to drop.
// Assumes: req is synchronous to clk; a drop during counting aborts the request.
module lane_mem_timer
    import lane_mem_pkg::*;
#(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic fire
);
    localparam int CNT_W = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYCLES);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    // Fire when the wait-state counter has run out.
    always_comb fire = (state == SEQ_COUNT) && req && (cnt == '0);

    // Request sequencing: idle, count wait states, hold until chip select drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (req) begin
                        state <= SEQ_COUNT;
                        cnt   <= CNT_LOAD;
                    end
                end
                SEQ_COUNT: begin
                    if (!req)          state <= SEQ_IDLE;
                    else if (fire)     state <= SEQ_HOLD;
                    else               cnt   <= cnt - 1'b1;
                end
                SEQ_HOLD: begin
                    if (!req) state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    AST_FIRE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(req)); // R2
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_COUNT) |-> (cnt <= CNT_LOAD)); // R2
    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R2

endmodule

// File: rtl/lane_mem_ram.sv
// Module: lane_mem_ram
// Word-wide RAM with one write port masked per byte lane and an
// asynchronous read port.
// Assumes: be[j] guards bits [8j+7:8j] (big-endian lane NB-1-j).
module lane_mem_ram
    import lane_mem_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [$clog2(DEPTH)-1:0]  idx,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [DATA_W/8-1:0]       be,
    output logic [DATA_W-1:0]         rdata
);
    localparam int NB = DATA_W / LANE_BITS;

    logic [DATA_W-1:0] mem [DEPTH];

    // Lane-masked write of the addressed word.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int j = 0; j < NB; j++) begin
                if (be[j]) mem[idx][j*LANE_BITS +: LANE_BITS] <= wdata[j*LANE_BITS +: LANE_BITS];
            end
        end
    end

    // Combinational read of the addressed word.
    always_comb rdata = mem[idx];

endmodule

// File: rtl/lane_mem_slave.sv
// Module: lane_mem_slave (top)
// Memory slave behind a synchronous chip-select handshake: decodes the
// address, adds wait states, writes enabled lanes, returns one-cycle
// acknowledges with an error flag for unmapped words.
// Assumes: address, rnw, wdata and be are held stable until the acknowledge.
module lane_mem_slave
    import lane_mem_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          DATA_W      = 32,
    parameter int          DEPTH       = 256,
    parameter int          REGION_LG   = 12,
    parameter logic [31:0] BASE_ADDR   = 32'h0000_4000,
    parameter int          CS_W        = 2,
    parameter int          CS_SEL      = 0,
    parameter int          WAIT_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CS_W-1:0]      cs,
    input  logic                 rnw,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W/8-1:0]  be,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_ack,
    output logic                 wr_ack,
    output logic                 err
);
    localparam int DEPTH_LG = $clog2(DEPTH);

    logic                 req;
    logic                 fire;
    logic                 region_hit;
    logic                 depth_ok;
    logic                 mapped;
    logic                 ram_we;
    logic [DEPTH_LG-1:0]  word_idx;
    logic [DATA_W-1:0]    ram_word;

    // Select the single chip-select bit that maps this memory.
    always_comb begin
        req    = cs[CS_SEL];
        mapped = region_hit && depth_ok;
        ram_we = fire && !rnw && mapped;
    end

    lane_mem_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
        .REGION_LG(REGION_LG), .BASE_ADDR(BASE_ADDR)
    ) decode_i (
        .addr(addr), .region_hit(region_hit), .depth_ok(depth_ok), .word_idx(word_idx)
    );

    lane_mem_timer #(.WAIT_CYCLES(WAIT_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .req(req), .fire(fire)
    );

    lane_mem_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ram_i (
        .clk(clk), .we(ram_we), .idx(word_idx), .wdata(wdata), .be(be), .rdata(ram_word)
    );

    // Response registers: one-cycle acknowledge, error and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ack  <= 1'b0;
            wr_ack  <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
        end else if (fire) begin
            rd_ack  <= rnw;
            wr_ack  <= !rnw;
            err     <= !mapped;
            rd_data <= (rnw && mapped) ? ram_word : '0;
        end else begin
            rd_ack  <= 1'b0;
            wr_ack  <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
        end
    end

    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rd_ack || wr_ack)); // R9
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack |-> (rd_data == '0)); // R10
    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ack && wr_ack)); // R3
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack || wr_ack) |=> !(rd_ack || wr_ack)); // R2
    AST_ACK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack || wr_ack) |-> $past(req)); // R11

endmodule

// File: tb/lane_mem_slave_tb_top.sv
// Directed bench for lane_mem_slave: one task per scenario.
module lane_mem_slave_tb_top;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 256;
    localparam int W      = 2;
    localparam logic [31:0] BASE = 32'h0000_4000;
    localparam int HOLD   = W + 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0]        cs = '0;
    logic              rnw = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [3:0]        be = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_ack, wr_ack, err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lane_mem_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .REGION_LG(12),
        .BASE_ADDR(BASE), .CS_W(2), .CS_SEL(0), .WAIT_CYCLES(W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .rnw(rnw), .wdata(wdata),
        .be(be), .rd_data(rd_data), .rd_ack(rd_ack), .wr_ack(wr_ack), .err(err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request: holds cs for HOLD cycles, records first ack index and counts.
    task automatic access(input bit r, input logic [31:0] a, input logic [31:0] d, input logic [3:0] b,
                          output logic [31:0] got, output bit gerr, output bit grd, output bit gwr,
                          output int first, output int nack);
        got = '0; gerr = 0; grd = 0; gwr = 0; first = -1; nack = 0;
        @(negedge clk);
        addr = a; rnw = r; wdata = d; be = b; cs = 2'b01;
        for (int k = 1; k <= HOLD; k++) begin
            @(negedge clk);
            if (rd_ack || wr_ack) begin
                nack++;
                if (first < 0) begin
                    first = k; got = rd_data; gerr = err; grd = rd_ack; gwr = wr_ack;
                end
            end else begin
                check(rd_data == '0, "R10", rd_data, 0);
                check(err == 1'b0, "R9", {31'b0, err}, 0);
            end
        end
        cs = 2'b00;
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b, output bit e);
        logic [31:0] g; bit grd, gwr; int f, n;
        access(1'b0, a, d, b, g, e, grd, gwr, f, n);
        check(gwr && !grd, "R3", {30'b0, grd, gwr}, 1);
        check(f == W + 2, "R2", f, W + 2);
        check(n == 1, "R2", n, 1);
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] g, output bit e);
        bit grd, gwr; int f, n;
        access(1'b1, a, '0, 4'hF, g, e, grd, gwr, f, n);
        check(grd && !gwr, "R3", {30'b0, grd, gwr}, 2);
        check(f == W + 2, "R2", f, W + 2);
        check(n == 1, "R2", n, 1);
    endtask

    task automatic t_reset();
        check(!rd_ack && !wr_ack && !err && rd_data == '0, "R1",
              {rd_data[27:0], rd_ack, wr_ack, err, 1'b0}, 0);
    endtask

    task automatic t_full_word();
        logic [31:0] g; bit e;
        wr(BASE + 32'd12, 32'hA1B2_C3D4, 4'hF, e);
        check(!e, "R6", {31'b0, e}, 0);
        rd(BASE + 32'd12, g, e);
        check(g == 32'hA1B2_C3D4, "R3", g, 32'hA1B2_C3D4);
        check(!e, "R6", {31'b0, e}, 0);
    endtask

    task automatic t_lanes();
        logic [31:0] g; bit e;
        wr(BASE + 32'd20, 32'h1122_3344, 4'hF, e);
        wr(BASE + 32'd20, 32'hAABB_CCDD, 4'b0011, e);
        rd(BASE + 32'd20, g, e);
        check(g == 32'h1122_CCDD, "R4", g, 32'h1122_CCDD);
        wr(BASE + 32'd20, 32'h5566_7788, 4'b1000, e);
        rd(BASE + 32'd20, g, e);
        check(g == 32'h5522_CCDD, "R5", g, 32'h5522_CCDD);
    endtask

    task automatic t_depth();
        logic [31:0] g; bit e;
        wr(BASE, 32'hCAFE_F00D, 4'hF, e);
        wr(BASE + DEPTH * 4, 32'hDEAD_BEEF, 4'hF, e);
        check(e, "R6", {31'b0, e}, 1);
        rd(BASE + DEPTH * 4, g, e);
        check(e, "R6", {31'b0, e}, 1);
        check(g == '0, "R6", g, 0);
        rd(BASE, g, e);
        check(g == 32'hCAFE_F00D, "R7", g, 32'hCAFE_F00D);
    endtask

    task automatic t_region();
        logic [31:0] g; bit e;
        wr(BASE + 32'h1000, 32'h0BAD_0BAD, 4'hF, e);
        check(e, "R8", {31'b0, e}, 1);
        rd(BASE, g, e);
        check(g == 32'hCAFE_F00D, "R8", g, 32'hCAFE_F00D);
        check(!e, "R8", {31'b0, e}, 0);
    endtask

    task automatic t_other_cs();
        int seen = 0;
        @(negedge clk);
        addr = BASE; rnw = 1'b1; be = 4'hF; cs = 2'b10;
        for (int k = 0; k < HOLD; k++) begin
            @(negedge clk);
            if (rd_ack || wr_ack || rd_data != '0) seen++;
        end
        cs = 2'b00;
        @(negedge clk);
        check(seen == 0, "R11", seen, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full_word();
        t_lanes();
        t_depth();
        t_region();
        t_other_cs();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule